// File: doc/BRIEF.md
# Flash Ready Status Poller

This block waits for a parallel NOR flash to finish an internal program or erase operation. A controller pulses `start` with a mode, an expected byte and an inter-read gap. The poller then issues status reads through a request/acknowledge read port. After each returned byte it decides whether the device is ready. When it is, it pulses `done`. If it gives up after a bounded number of comparisons, it pulses `timeout` instead.

There are two detection modes. In toggle mode the device flips bit 6 on every read while it is busy, so readiness means that two reads in a row return the same bit 6. In data-polling mode the device returns the complement of the written bit 7 until it is finished, so readiness means that bit 7 of a read equals bit 7 of the expected byte. A programmable gap, counted in clock cycles, can separate consecutive reads. This serves slow erase waits: about 8 ms corresponds to 1,600,000 cycles at 200 MHz. The number of comparisons is reported and held after completion. A flag marks waits that needed an unusually large number of comparisons.

Top module: `flash_ready_poller`

## Requirements
- R1: After a synchronous reset, `busy`, `rd_req`, `done`, `timeout`, `loop_excess` are 0 and `loop_cnt` is 0.
- R2: In toggle mode (`mode`=0) the first returned byte only sets the reference bit 6 and is not counted. Every later byte is one comparison, which increments `loop_cnt`. The operation completes when bit 6 (mask 0x40) of the byte equals the reference.
- R3: In toggle mode, after an unequal comparison the bit 6 of the newest byte becomes the reference for the next comparison.
- R4: In data-polling mode (`mode`=1) every returned byte is a comparison. Only bit 7 (mask 0x80) of `exp_data` and of `rd_data` take part, and bits 6..0 of both have no effect.
- R5: When comparison number MAX_ITER fails, `timeout` pulses, `loop_cnt` equals MAX_ITER and no further read is requested. `loop_cnt` never exceeds MAX_ITER.
- R6: `loop_excess` rises when `loop_cnt` exceeds EXCESS_LIM and holds until the next accepted start.
- R7: After an acknowledged read that does not end the operation, `rd_req` stays low for exactly `gap_cycles` cycles. With a gap of 0 it is re-asserted in the very next cycle. The gap is used in both modes.
- R8: `done` and `timeout` are single-cycle pulses that are never high together. They appear in the cycle after the clock edge that accepted the final `rd_ack`. `loop_cnt` stays stable until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored. The running operation keeps its mode, expected bit and gap.
- R10: `rd_req` stays high until the cycle in which `rd_ack` is sampled high. `rd_data` is taken only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a wait (accepted only when idle) |
| mode | input | 1 | 0 = toggle detection, 1 = data polling |
| exp_data | input | 8 | Expected byte; only bit 7 is used |
| gap_cycles | input | GAP_W | Idle cycles between reads |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read completion strobe |
| rd_data | input | 8 | Byte returned with `rd_ack` |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle pulse: device ready |
| timeout | output | 1 | One-cycle pulse: iteration bound reached |
| loop_cnt | output | CNT_W | Comparisons made in the last/current wait |
| loop_excess | output | 1 | Comparison count exceeded EXCESS_LIM |

## Verification
Every output is registered or decoded from a registered state. A start accepted at an edge therefore shows `busy` and `rd_req` in the following cycle. An acknowledged read updates `loop_cnt` and raises `done` or `timeout` in the cycle after its edge. After a gap of N, `rd_req` returns exactly N+1 cycles after the acknowledging edge. The bench keeps a behavioural model that advances on the same edges from the same inputs, and compares all outputs at the falling edge of every cycle. Each timing offset is therefore checked in the exact cycle it is due. Directed checks after each wait then confirm the hand-computed comparison counts and outcomes.

// File: rtl/frp_pkg.sv
package frp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_GAP  = 2'd2
  } frp_state_t;

  typedef enum logic {
    MODE_TOGGLE = 1'b0,
    MODE_DATA   = 1'b1
  } frp_mode_t;

  localparam int TOGGLE_BIT = 6;
  localparam int POLL_BIT   = 7;
endpackage

// File: rtl/frp_gap_timer.sv
module frp_gap_timer #(
  parameter int GAP_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] len,
  output logic             expire
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= len;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == GAP_W'(1));

  // R7: once the last gap cycle is reached the timer drains to zero
  a_r7_gap_drains: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/frp_status_cmp.sv
module frp_status_cmp
  import frp_pkg::*;
(
  input  frp_mode_t  mode,
  input  logic [7:0] rd_data,
  input  logic [7:0] exp_data,
  input  logic       ref_bit,
  output logic       sample_bit,
  output logic       match
);
  always_comb begin
    if (mode == MODE_DATA) begin
      sample_bit = rd_data[POLL_BIT];
      match      = (rd_data[POLL_BIT] == exp_data[POLL_BIT]);
    end else begin
      sample_bit = rd_data[TOGGLE_BIT];
      match      = (rd_data[TOGGLE_BIT] == ref_bit);
    end
  end
endmodule

// File: rtl/frp_iter_cnt.sv
module frp_iter_cnt #(
  parameter int unsigned MAX_ITER   = 32'h0FFF_FFFF,
  parameter int unsigned EXCESS_LIM = 32'h0010_0000,
  parameter int          CNT_W      = $clog2(MAX_ITER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic             last,
  output logic [CNT_W-1:0] cnt,
  output logic             excess
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ITER);
  localparam logic [CNT_W:0]   XLIM  = (CNT_W+1)'(EXCESS_LIM);

  logic [CNT_W-1:0] cnt_q;
  logic             excess_q;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign last   = (cnt_nx >= {1'b0, LIMIT});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      excess_q <= 1'b0;
    end else if (inc) begin
      cnt_q <= cnt_nx[CNT_W-1:0];
      if (cnt_nx > XLIM) excess_q <= 1'b1;
    end
  end

  assign cnt    = cnt_q;
  assign excess = excess_q;

  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  a_r6_excess_sticky: assert property (@(posedge clk) disable iff (rst)
    (excess_q && !clr) |=> excess_q);
endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
  import frp_pkg::*;
#(
  parameter int unsigned MAX_ITER   = 32'h0FFF_FFFF,
  parameter int unsigned EXCESS_LIM = 32'h0010_0000,
  parameter int          GAP_W      = 21,
  parameter int          CNT_W      = $clog2(MAX_ITER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [7:0]       exp_data,
  input  logic [GAP_W-1:0] gap_cycles,
  output logic             rd_req,
  input  logic             rd_ack,
  input  logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic [CNT_W-1:0] loop_cnt,
  output logic             loop_excess
);
  frp_state_t       state_q;
  frp_mode_t        mode_q;
  logic [7:0]       exp_q;
  logic [GAP_W-1:0] gap_q;
  logic             ref_q, have_ref_q;
  logic             done_q, to_q;

  logic sample_bit, match, last, expire;
  logic accept, ack_ok, need_ref, advance, finish_ok, finish_to;

  assign accept    = (state_q == ST_IDLE) && start;
  assign ack_ok    = (state_q == ST_READ) && rd_ack;
  assign need_ref  = (mode_q == MODE_TOGGLE) && !have_ref_q;
  assign finish_ok = ack_ok && !need_ref && match;
  assign finish_to = ack_ok && !need_ref && !match && last;
  assign advance   = ack_ok && !finish_ok && !finish_to;

  frp_status_cmp u_cmp (
    .mode       (mode_q),
    .rd_data    (rd_data),
    .exp_data   (exp_q),
    .ref_bit    (ref_q),
    .sample_bit (sample_bit),
    .match      (match)
  );

  frp_iter_cnt #(
    .MAX_ITER   (MAX_ITER),
    .EXCESS_LIM (EXCESS_LIM),
    .CNT_W      (CNT_W)
  ) u_iter (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .inc    (ack_ok && !need_ref),
    .last   (last),
    .cnt    (loop_cnt),
    .excess (loop_excess)
  );

  frp_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk    (clk),
    .rst    (rst),
    .load   (advance && (gap_q != '0)),
    .len    (gap_q),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_TOGGLE;
      exp_q      <= '0;
      gap_q      <= '0;
      ref_q      <= 1'b0;
      have_ref_q <= 1'b0;
      done_q     <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      done_q <= finish_ok;
      to_q   <= finish_to;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q    <= ST_READ;
          mode_q     <= frp_mode_t'(mode);
          exp_q      <= exp_data;
          gap_q      <= gap_cycles;
          have_ref_q <= 1'b0;
        end
        ST_READ: begin
          if (finish_ok || finish_to) begin
            state_q <= ST_IDLE;
          end else if (advance) begin
            have_ref_q <= 1'b1;
            ref_q      <= sample_bit;
            state_q    <= (gap_q == '0) ? ST_READ : ST_GAP;
          end
        end
        ST_GAP: if (expire) state_q <= ST_READ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req  = (state_q == ST_READ);
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign timeout = to_q;

  a_r8_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_timeout_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
  a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req);
  a_r8_cnt_held: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(loop_cnt));
  a_r9_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_q));
endmodule

// File: tb/flash_ready_poller_test.sv
module flash_ready_poller_test;
  localparam int unsigned MAXI = 12;
  localparam int unsigned XLIM = 4;
  localparam int GW = 21;
  localparam int CW = $clog2(MAXI + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, mode = 1'b0;
  logic [7:0] exp_data = '0;
  logic [GW-1:0] gap_cycles = '0;
  logic rd_ack = 1'b0;
  logic [7:0] rd_data = '0;
  logic rd_req, busy, done, timeout, loop_excess;
  logic [CW-1:0] loop_cnt;

  always #2.5 clk = ~clk;

  flash_ready_poller #(.MAX_ITER(MAXI), .EXCESS_LIM(XLIM), .GAP_W(GW)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .exp_data(exp_data),
    .gap_cycles(gap_cycles), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .timeout(timeout), .loop_cnt(loop_cnt),
    .loop_excess(loop_excess));

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;
  bit cmp_en = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  int ph = 0, left = 0, m_gap = 0, m_cnt = 0;
  bit m_mode, m_exp, m_ref, m_have, e_done, e_to, e_exc;
  int seen_done = 0, seen_to = 0;

  always @(posedge clk) begin
    cycles++;
    cmp_en <= 1'b1;
    if (rst) begin
      ph = 0; m_cnt = 0; e_done = 0; e_to = 0; e_exc = 0;
    end else begin
      e_done = 0; e_to = 0;
      if (ph == 0) begin
        if (start) begin
          ph = 1; m_mode = mode; m_exp = exp_data[7]; m_gap = int'(gap_cycles);
          m_have = 0; m_cnt = 0; e_exc = 0;
        end
      end else if (ph == 1) begin
        if (rd_ack) begin
          bit b, nxt;
          b = m_mode ? rd_data[7] : rd_data[6];
          nxt = 0;
          if (!m_mode && !m_have) begin
            m_have = 1; m_ref = b; nxt = 1;
          end else begin
            m_cnt++;
            if (m_cnt > int'(XLIM)) e_exc = 1;
            if (m_mode ? (b == m_exp) : (b == m_ref)) begin e_done = 1; ph = 0; end
            else if (m_cnt >= int'(MAXI)) begin e_to = 1; ph = 0; end
            else begin m_ref = b; nxt = 1; end
          end
          if (nxt) begin
            if (m_gap == 0) ph = 1; else begin ph = 2; left = m_gap; end
          end
        end
      end else begin
        left--;
        if (left == 0) ph = 1;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R1/R9 busy", busy, ph != 0);
      chk("R7/R10 rd_req", rd_req, ph == 1);
      chk("R8 done", done, e_done);
      chk("R5 timeout", timeout, e_to);
      chk("R2 loop_cnt", int'(loop_cnt), m_cnt);
      chk("R6 loop_excess", loop_excess, e_exc);
      if (done) seen_done++;
      if (timeout) seen_to++;
    end
  end

  // read responder
  logic [7:0] q[$];
  int lat = 0, waitc = 0;
  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack <= 1'b0;
    end else if (rd_req === 1'b1) begin
      if (waitc >= lat) begin
        rd_ack <= 1'b1;
        rd_data <= (q.size() > 0) ? q.pop_front() : 8'hFF;
        waitc = 0;
      end else waitc++;
    end
  end

  task automatic pulse_start(bit md, logic [7:0] ex, int gp);
    @(negedge clk);
    start = 1'b1; mode = md; exp_data = ex; gap_cycles = GW'(gp);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy !== 1'b0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run(bit md, logic [7:0] ex, int gp, int l, int cnt_exp,
                     bit dn, bit ex_flag, string tag);
    seen_done = 0; seen_to = 0; lat = l; waitc = 0;
    pulse_start(md, ex, gp);
    wait_idle();
    chk({tag, " count"}, int'(loop_cnt), cnt_exp);
    chk({tag, " done pulses"}, seen_done, dn ? 1 : 0);
    chk({tag, " timeout pulses"}, seen_to, dn ? 0 : 1);
    chk({tag, " excess"}, loop_excess, ex_flag);
    q.delete();
  endtask

  initial begin
    fork
      begin
        repeat (40000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset busy", busy, 0);
    chk("R1 reset rd_req", rd_req, 0);
    chk("R1 reset loop_cnt", int'(loop_cnt), 0);

    // R2 R3: toggle, back-to-back reads
    q = '{8'h40, 8'h00, 8'h40, 8'h40};
    run(1'b0, 8'h00, 0, 0, 3, 1, 0, "R2 R3 toggle");

    // R6 R7: toggle with gap and slow ack, exceeds the excess limit
    q = '{8'hBF, 8'hFF, 8'hBF, 8'hFF, 8'h00, 8'h00};
    run(1'b0, 8'h00, 3, 2, 5, 1, 1, "R6 R7 toggle gap");

    // R4: data polling, only bit 7 of the expected byte counts
    q = '{8'h7F, 8'h00, 8'h80};
    run(1'b1, 8'h95, 0, 1, 3, 1, 0, "R4 poll high");
    q = '{8'h00};
    run(1'b1, 8'h7F, 2, 0, 1, 1, 0, "R4 poll low");

    // R5: bound reached with alternating toggle bit
    for (int i = 0; i < 20; i++) q.push_back((i % 2) ? 8'h00 : 8'h40);
    run(1'b0, 8'h00, 1, 0, int'(MAXI), 0, 1, "R5 timeout");
    chk("R5 no read after timeout", rd_req, 0);

    // R9: start while busy is ignored
    q = '{8'h00, 8'h00, 8'h80};
    seen_done = 0; seen_to = 0; lat = 0; waitc = 0;
    pulse_start(1'b1, 8'h80, 5);
    repeat (3) @(negedge clk);
    start = 1'b1; mode = 1'b0; exp_data = 8'h00; gap_cycles = '0;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R9 count after ignored start", int'(loop_cnt), 3);
    chk("R9 done", seen_done, 1);
    q.delete();

    // R8: count held while idle
    repeat (10) @(negedge clk);
    chk("R8 held count", int'(loop_cnt), 3);
    chk("R8 idle busy", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule